// File: doc/BRIEF.md
# Contactless Tag Command Sequencer with Slotted Anticollision

This block is the command layer of a proximity tag. It receives request frames that have already been decoded and CRC-checked. They arrive one byte at a time on a valid strobe and are closed by a frame-done strobe. The block tracks which protocol state the tag is in and decides whether the tag answers and what kind of answer it gives. It also issues read, write and select strobes towards the block memory. Frame coding, the radio path and the memory contents belong to other blocks.

The tag keeps an 8-bit chip identifier. Its low nibble doubles as the anticollision slot number. A free-running 16-bit maximal-length LFSR supplies a fresh identifier on power-up and on every Initiate. The same LFSR supplies a fresh slot nibble on every slot-0 poll, so the value a tag draws depends on the cycle its command arrives. A fixed-identifier option input bypasses the randomisation completely.

Every answer is requested one clock after the frame-done strobe. The answer is a pulse on `respValid`, and `respKind` tells the framer what to send: 1 = chip identifier (value on `respChipId`), 2 = block data, 3 = 64-bit UID. No pulse means silence.

Top module: `tag_cmd_fsm`

## Requirements
- R1: After reset the tag is in the ready state, where only Initiate (bytes 06h, 00h) draws a response. While `fieldOn` is low the tag is powered off and ignores every frame. When `fieldOn` rises again the tag returns to the ready state.
- R2: Initiate in the ready or inventory state loads a new random chip ID, moves the tag to inventory and answers with kind 1 and that ID. Successive Initiates arriving at different times give differing IDs.
- R3: The slot-0 poll (bytes 06h, 04h) in inventory loads a new random value into ID bits 3..0 and keeps bits 7..4. The tag answers with kind 1 only if the new nibble is 0.
- R4: A one-byte slot marker has low nibble 6 and a slot number 1..15 in the high nibble. In inventory it draws a kind-1 answer only when that slot number equals ID bits 3..0.
- R5: Select (bytes 0Eh, id) with a matching ID moves inventory or deselected to selected. It answers with kind 1 and pulses `memSelect`. A non-matching Select in the selected state moves the tag to deselected, silently. In inventory a non-matching Select has no effect.
- R6: In the selected state, Read (08h, addr) with addr below 16 or equal to 255 pulses `memRead` with `memAddr` = addr and answers with kind 2. Any other address, and any Read outside the selected state, is ignored.
- R7: In the selected state, Write (09h, addr, d0, d1, d2, d3) to a valid address pulses `memWrite` with `memWdata` = {d3,d2,d1,d0} and draws no answer.
- R8: In the selected state, the one-byte UID request (0Bh) answers with kind 3.
- R9: The selected state ignores Initiate, the slot-0 poll and slot markers.
- R10: Completion (0Fh) in the selected state moves the tag to deactivated, silently. A deactivated tag ignores everything until the field is lost.
- R11: Reset-to-inventory (0Ch) in the selected state moves the tag back to inventory, silently.
- R12: The deselected state reacts only to a matching Select.
- R13: While `fixedIdEn` is high the chip ID equals `fixedId` and is never randomised. This includes the slot nibble used by the poll and the slot markers.
- R14: A frame whose length does not fit its opcode is ignored. This covers a frame longer than six bytes and a slot-marker byte whose slot number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fieldOn | input | 1 | High while the carrier powers the tag |
| rxValid | input | 1 | One request byte is present on rxByte |
| rxByte | input | 8 | Request byte, first byte = opcode |
| rxDone | input | 1 | Frame complete and CRC good |
| fixedIdEn | input | 1 | Use fixedId instead of a random ID |
| fixedId | input | 8 | Preset chip identifier |
| respValid | output | 1 | Answer request pulse |
| respKind | output | 2 | 1 chip ID, 2 block data, 3 UID |
| respChipId | output | 8 | Current chip identifier |
| memRead | output | 1 | Block read strobe |
| memWrite | output | 1 | Block write strobe |
| memSelect | output | 1 | Pulse on a matching Select |
| memAddr | output | 8 | Block address of the read or write |
| memWdata | output | 32 | Write data, first data byte in bits 7..0 |

## Verification
The bench keeps the default parameters: 16 blocks, the system block at 255, 32-bit blocks (six-byte write frames) and the 16-bit LFSR. With these values every opcode length, the address limits 15/16/255 and a full write are in reach. A preset ID of 35h puts the slot nibble at 5, which makes the table of poll and slot-marker outcomes deterministic. In random mode the bench compares only values visible at the ports. After each poll it sweeps slot markers 1 to 15 and expects exactly one answer across the poll and the sweep, with the high nibble held.

// File: rtl/tag_pkg.sv
package tag_pkg;

  localparam int ID_W = 8;

  typedef enum logic [2:0] {
    ST_OFF, ST_READY, ST_INV, ST_SEL, ST_DESEL, ST_DEACT
  } tag_state_e;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_ID    = 2'd1,
    RESP_BLOCK = 2'd2,
    RESP_UID   = 2'd3
  } resp_kind_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic loadId;
    logic loadSlot;
    logic flush;
  } dp_ctrl_t;

  localparam logic [7:0] OP_ANTI   = 8'h06;
  localparam logic [7:0] SUB_INIT  = 8'h00;
  localparam logic [7:0] SUB_POLL  = 8'h04;
  localparam logic [3:0] SLOT_LOW  = 4'h6;
  localparam logic [7:0] OP_SELECT = 8'h0E;
  localparam logic [7:0] OP_FINISH = 8'h0F;
  localparam logic [7:0] OP_REINV  = 8'h0C;
  localparam logic [7:0] OP_READ   = 8'h08;
  localparam logic [7:0] OP_WRITE  = 8'h09;
  localparam logic [7:0] OP_UID    = 8'h0B;

endpackage

// File: rtl/tag_datapath.sv
module tag_datapath
  import tag_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dp_ctrl_t               ctl,
  input  logic                   rxValid,
  input  logic [7:0]             rxByte,
  input  logic                   fixedIdEn,
  input  logic [ID_W-1:0]        fixedId,
  output logic [MAX_BYTES*8-1:0] frameBytes,
  output logic [LEN_W-1:0]       frameLen,
  output logic                   frameOvf,
  output logic [ID_W-1:0]        chipId,
  output logic [ID_W-1:0]        nextId,
  output logic [3:0]             nextSlot
);

  logic [LFSR_W-1:0] lfsr;
  logic [ID_W-1:0]   chipIdReg;

  // free-running Galois LFSR
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lfsr <= LFSR_SEED;
    else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ LFSR_TAPS;
    else              lfsr <= lfsr >> 1;
  end

  // byte collection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameLen <= '0;
      frameOvf <= 1'b0;
    end else if (ctl.flush) begin
      frameLen <= '0;
      frameOvf <= 1'b0;
    end else if (rxValid) begin
      if (frameLen < LEN_W'(MAX_BYTES)) frameLen <= frameLen + 1'b1;
      else                              frameOvf <= 1'b1;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (!ctl.flush && rxValid && frameLen == LEN_W'(g)) q <= rxByte;
    end
    assign frameBytes[g*8 +: 8] = q;
  end

  assign nextId   = fixedIdEn ? fixedId : lfsr[ID_W-1:0];
  assign nextSlot = fixedIdEn ? fixedId[3:0] : lfsr[3:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             chipIdReg <= LFSR_SEED[ID_W-1:0];
    else if (ctl.loadId)   chipIdReg <= nextId;
    else if (ctl.loadSlot) chipIdReg[3:0] <= nextSlot;
  end

  assign chipId = fixedIdEn ? fixedId : chipIdReg;

  // poll redraws only the slot nibble
  p_slot_keeps_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadSlot && !ctl.loadId) |=> chipIdReg[7:4] == $past(chipIdReg[7:4]));

  p_len_bound_r14: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && frameOvf && !ctl.flush) |=> frameOvf);

endmodule

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import tag_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int SYS_BLOCK = 255,
  parameter int BLOCK_W = 32,
  localparam int FRAME_MAX = 2 + BLOCK_W / 8,
  localparam int LEN_W = $clog2(FRAME_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fieldOn,
  input  logic                   rxDone,
  input  logic [FRAME_MAX*8-1:0] frameBytes,
  input  logic [LEN_W-1:0]       frameLen,
  input  logic                   frameOvf,
  input  logic [ID_W-1:0]        chipId,
  input  logic [3:0]             nextSlot,
  output dp_ctrl_t               ctl,
  output logic                   respValid,
  output resp_kind_e             respKind,
  output logic                   memRead,
  output logic                   memWrite,
  output logic                   memSelect,
  output logic [7:0]             memAddr,
  output logic [BLOCK_W-1:0]     memWdata
);

  tag_state_e state, nextState;
  logic [7:0] b0, b1;
  logic len1, len2, lenW;
  logic isInit, isPoll, isSlot, isSelect, isFinish, isReinv, isRead, isWrite, isUid;
  logic addrOk, idMatch;
  logic ansId, doRead, doWrite, doUid, doSel;

  assign b0 = frameBytes[7:0];
  assign b1 = frameBytes[15:8];
  assign len1 = !frameOvf && frameLen == LEN_W'(1);
  assign len2 = !frameOvf && frameLen == LEN_W'(2);
  assign lenW = !frameOvf && frameLen == LEN_W'(FRAME_MAX);

  assign isInit   = len2 && b0 == OP_ANTI && b1 == SUB_INIT;
  assign isPoll   = len2 && b0 == OP_ANTI && b1 == SUB_POLL;
  assign isSlot   = len1 && b0[3:0] == SLOT_LOW && b0[7:4] != 4'd0;
  assign isSelect = len2 && b0 == OP_SELECT;
  assign isFinish = len1 && b0 == OP_FINISH;
  assign isReinv  = len1 && b0 == OP_REINV;
  assign isRead   = len2 && b0 == OP_READ;
  assign isWrite  = lenW && b0 == OP_WRITE;
  assign isUid    = len1 && b0 == OP_UID;
  assign addrOk   = (b1 < 8'(NUM_BLOCKS)) || (b1 == 8'(SYS_BLOCK));
  assign idMatch  = b1 == chipId;

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.flush = rxDone || !fieldOn;
    ansId     = 1'b0;
    doRead    = 1'b0;
    doWrite   = 1'b0;
    doUid     = 1'b0;
    doSel     = 1'b0;
    if (!fieldOn) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF: begin
          nextState  = ST_READY;
          ctl.loadId = 1'b1;
        end
        ST_READY: if (rxDone && isInit) begin
          nextState  = ST_INV;
          ctl.loadId = 1'b1;
          ansId      = 1'b1;
        end
        ST_INV: if (rxDone) begin
          if (isInit) begin
            ctl.loadId = 1'b1;
            ansId      = 1'b1;
          end else if (isPoll) begin
            ctl.loadSlot = 1'b1;
            ansId        = nextSlot == 4'd0;
          end else if (isSlot) begin
            ansId = chipId[3:0] == b0[7:4];
          end else if (isSelect && idMatch) begin
            nextState = ST_SEL;
            ansId     = 1'b1;
            doSel     = 1'b1;
          end
        end
        ST_SEL: if (rxDone) begin
          if (isSelect) begin
            if (idMatch) begin
              ansId = 1'b1;
              doSel = 1'b1;
            end else begin
              nextState = ST_DESEL;
            end
          end else if (isRead && addrOk) begin
            doRead = 1'b1;
          end else if (isWrite && addrOk) begin
            doWrite = 1'b1;
          end else if (isUid) begin
            doUid = 1'b1;
          end else if (isFinish) begin
            nextState = ST_DEACT;
          end else if (isReinv) begin
            nextState = ST_INV;
          end
        end
        ST_DESEL: if (rxDone && isSelect && idMatch) begin
          nextState = ST_SEL;
          ansId     = 1'b1;
          doSel     = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      respValid <= 1'b0;
      respKind  <= RESP_NONE;
      memRead   <= 1'b0;
      memWrite  <= 1'b0;
      memSelect <= 1'b0;
      memAddr   <= '0;
      memWdata  <= '0;
    end else begin
      state     <= nextState;
      respValid <= ansId || doRead || doUid;
      respKind  <= ansId ? RESP_ID : doRead ? RESP_BLOCK : doUid ? RESP_UID : RESP_NONE;
      memRead   <= doRead;
      memWrite  <= doWrite;
      memSelect <= doSel;
      if (doRead || doWrite) memAddr <= b1;
      if (doWrite) memWdata <= frameBytes[FRAME_MAX*8-1:16];
    end
  end

  p_reply_after_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(rxDone));

  p_ready_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && fieldOn && !(rxDone && isInit)) |=> state == ST_READY);

  p_select_replies_r5: assert property (@(posedge clk) disable iff (!rstN)
    memSelect |-> (respValid && respKind == RESP_ID));

  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> !respValid);

  p_deact_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEACT && fieldOn) |=> state == ST_DEACT);

endmodule

// File: rtl/tag_cmd_fsm.sv
module tag_cmd_fsm
  import tag_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int SYS_BLOCK = 255,
  parameter int BLOCK_W = 32,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int FRAME_MAX = 2 + BLOCK_W / 8,
  localparam int LEN_W = $clog2(FRAME_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fieldOn,
  input  logic               rxValid,
  input  logic [7:0]         rxByte,
  input  logic               rxDone,
  input  logic               fixedIdEn,
  input  logic [7:0]         fixedId,
  output logic               respValid,
  output logic [1:0]         respKind,
  output logic [7:0]         respChipId,
  output logic               memRead,
  output logic               memWrite,
  output logic               memSelect,
  output logic [7:0]         memAddr,
  output logic [BLOCK_W-1:0] memWdata
);

  dp_ctrl_t               ctl;
  logic [FRAME_MAX*8-1:0] frameBytes;
  logic [LEN_W-1:0]       frameLen;
  logic                   frameOvf;
  logic [ID_W-1:0]        chipId, nextId;
  logic [3:0]             nextSlot;
  resp_kind_e             kindE;

  tag_datapath #(
    .MAX_BYTES(FRAME_MAX), .LFSR_W(LFSR_W),
    .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxValid(rxValid), .rxByte(rxByte),
    .fixedIdEn(fixedIdEn), .fixedId(fixedId), .frameBytes(frameBytes),
    .frameLen(frameLen), .frameOvf(frameOvf), .chipId(chipId),
    .nextId(nextId), .nextSlot(nextSlot)
  );

  tag_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .SYS_BLOCK(SYS_BLOCK), .BLOCK_W(BLOCK_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .fieldOn(fieldOn), .rxDone(rxDone),
    .frameBytes(frameBytes), .frameLen(frameLen), .frameOvf(frameOvf),
    .chipId(chipId), .nextSlot(nextSlot), .ctl(ctl),
    .respValid(respValid), .respKind(kindE), .memRead(memRead),
    .memWrite(memWrite), .memSelect(memSelect), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  assign respKind   = kindE;
  assign respChipId = chipId;

endmodule

// File: tb/test_tag_cmd_fsm.sv
module test_tag_cmd_fsm;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldOn = 1'b1;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxDone = 1'b0;
  logic fixedIdEn = 1'b0;
  logic [7:0] fixedId = 8'h35;
  logic respValid, memRead, memWrite, memSelect;
  logic [1:0] respKind;
  logic [7:0] respChipId, memAddr;
  logic [31:0] memWdata;

  int checks = 0;
  int fails = 0;

  logic gV, gR, gW, gS;
  logic [1:0] gK;
  logic [7:0] gId, gAddr;
  logic [31:0] gData;

  always #5 clk = ~clk;

  tag_cmd_fsm i_tag_cmd_fsm (
    .clk(clk), .rstN(rstN), .fieldOn(fieldOn), .rxValid(rxValid),
    .rxByte(rxByte), .rxDone(rxDone), .fixedIdEn(fixedIdEn), .fixedId(fixedId),
    .respValid(respValid), .respKind(respKind), .respChipId(respChipId),
    .memRead(memRead), .memWrite(memWrite), .memSelect(memSelect),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  // entry: {req[3:0], len[2:0], kind[1:0], rd, wr, sel, bytes[47:0] first byte low}
  localparam int NV = 34;
  localparam logic [59:0] VECS [NV] = '{
    {4'd1,  3'd2, 2'd0, 3'b000, 48'h0308},          // R1 read while ready
    {4'd1,  3'd1, 2'd0, 3'b000, 48'h56},            // R1 slot marker while ready
    {4'd13, 3'd2, 2'd1, 3'b000, 48'h0006},          // R13 initiate answers preset id
    {4'd14, 3'd1, 2'd0, 3'b000, 48'h06},            // R14 slot number 0 reserved
    {4'd3,  3'd2, 2'd0, 3'b000, 48'h0406},          // R3 poll, nibble 5 stays silent
    {4'd4,  3'd1, 2'd0, 3'b000, 48'h46},            // R4 wrong slot
    {4'd4,  3'd1, 2'd1, 3'b000, 48'h56},            // R4 matching slot
    {4'd14, 3'd2, 2'd0, 3'b000, 48'h0056},          // R14 slot marker with extra byte
    {4'd6,  3'd2, 2'd0, 3'b000, 48'h0308},          // R6 read in inventory
    {4'd5,  3'd2, 2'd0, 3'b000, 48'h360E},          // R5 select mismatch in inventory
    {4'd14, 3'd1, 2'd0, 3'b000, 48'h0E},            // R14 select without id
    {4'd5,  3'd2, 2'd1, 3'b001, 48'h350E},          // R5 select match
    {4'd9,  3'd2, 2'd0, 3'b000, 48'h0006},          // R9 initiate ignored
    {4'd9,  3'd1, 2'd0, 3'b000, 48'h56},            // R9 slot marker ignored
    {4'd9,  3'd2, 2'd0, 3'b000, 48'h0406},          // R9 poll ignored
    {4'd6,  3'd2, 2'd2, 3'b100, 48'h0F08},          // R6 last block
    {4'd6,  3'd2, 2'd0, 3'b000, 48'h1008},          // R6 address 16 ignored
    {4'd6,  3'd2, 2'd2, 3'b100, 48'hFF08},          // R6 system block
    {4'd7,  3'd6, 2'd0, 3'b010, 48'h443322110709},  // R7 write
    {4'd14, 3'd5, 2'd0, 3'b000, 48'h3322110709},    // R14 short write
    {4'd8,  3'd1, 2'd3, 3'b000, 48'h0B},            // R8 uid
    {4'd14, 3'd2, 2'd0, 3'b000, 48'h000B},          // R14 uid with extra byte
    {4'd5,  3'd2, 2'd0, 3'b000, 48'h990E},          // R5 mismatch deselects
    {4'd12, 3'd1, 2'd0, 3'b000, 48'h0B},            // R12 uid ignored
    {4'd12, 3'd2, 2'd0, 3'b000, 48'h0006},          // R12 initiate ignored
    {4'd12, 3'd2, 2'd0, 3'b000, 48'h0F08},          // R12 read ignored
    {4'd12, 3'd2, 2'd1, 3'b001, 48'h350E},          // R12 matching select
    {4'd11, 3'd1, 2'd0, 3'b000, 48'h0C},            // R11 back to inventory
    {4'd11, 3'd2, 2'd0, 3'b000, 48'h0308},          // R11 read now ignored
    {4'd11, 3'd1, 2'd1, 3'b000, 48'h56},            // R11 slot marker answered
    {4'd5,  3'd2, 2'd1, 3'b001, 48'h350E},          // R5 reselect
    {4'd10, 3'd1, 2'd0, 3'b000, 48'h0F},            // R10 completion
    {4'd10, 3'd2, 2'd0, 3'b000, 48'h350E},          // R10 select ignored
    {4'd10, 3'd2, 2'd0, 3'b000, 48'h0006}           // R10 initiate ignored
  };

  task automatic check(input string req, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input int len, input logic [55:0] bytes, input int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxByte  = bytes[i*8 +: 8];
    end
    @(negedge clk);
    rxValid = 1'b0;
    rxDone  = 1'b1;
    @(negedge clk);
    rxDone = 1'b0;
    gV = respValid; gK = respKind; gId = respChipId;
    gR = memRead; gW = memWrite; gS = memSelect;
    gAddr = memAddr; gData = memWdata;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] idA;
    int hits;
    logic [7:0] ids [8];
    int diff;

    // reset state, R1
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", {respValid, memRead, memWrite, memSelect} == 4'b0,
          {respValid, memRead, memWrite, memSelect}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // random identifier, R2
    sendFrame(2, 56'h0006, 1);
    idA = gId;
    check("R2", gV && gK == 2'd1, {gV, gK}, {1'b1, 2'd1});

    // poll then sweep slot markers, R3 and R4
    for (int round = 0; round < 3; round++) begin
      hits = 0;
      sendFrame(2, 56'h0406, round * 3);
      if (gV) begin
        hits++;
        check("R3", gK == 2'd1 && gId[3:0] == 4'd0 && gId[7:4] == idA[7:4],
              {gK, gId}, {2'd1, idA[7:4], 4'd0});
      end
      for (int sn = 1; sn < 16; sn++) begin
        sendFrame(1, {48'h0, 4'(sn), 4'h6}, 0);
        if (gV) begin
          hits++;
          check("R4", gK == 2'd1 && gId == {idA[7:4], 4'(sn)},
                {gK, gId}, {2'd1, idA[7:4], 4'(sn)});
        end
      end
      check("R4", hits == 1, hits, 1);
    end

    // successive initiates give differing ids, R2
    for (int k = 0; k < 8; k++) begin
      sendFrame(2, 56'h0006, k + 1);
      ids[k] = gId;
    end
    diff = 0;
    for (int k = 1; k < 8; k++) if (ids[k] != ids[k-1]) diff++;
    check("R2", diff > 0, diff, 1);

    // over-long frame ignored, R14: seven bytes of an initiate
    sendFrame(7, 56'h0006, 0);
    check("R14", !gV, gV, 0);

    // preset identifier table
    fixedIdEn = 1'b1;
    doReset();
    for (int v = 0; v < NV; v++) begin
      logic [59:0] e;
      logic [3:0] rq;
      logic [1:0] k;
      logic [2:0] rws;
      logic [47:0] by;
      logic [53:0] actV, expV;
      e = VECS[v];
      rq = e[59:56]; k = e[52:51]; rws = e[50:48]; by = e[47:0];
      sendFrame(int'(e[55:53]), {8'h0, by}, 1);
      expV = {k != 2'd0, k, rws, (k == 2'd1) ? 8'h35 : 8'h0,
              (rws[2] | rws[1]) ? by[15:8] : 8'h0, rws[1] ? by[47:16] : 32'h0};
      actV = {gV, gK, gR, gW, gS, (k == 2'd1) ? gId : 8'h0,
              (rws[2] | rws[1]) ? gAddr : 8'h0, rws[1] ? gData : 32'h0};
      check($sformatf("R%0d vector %0d", rq, v), actV == expV, 64'(actV), 64'(expV));
    end

    // field loss and return, R1
    fieldOn = 1'b0;
    repeat (2) @(negedge clk);
    sendFrame(2, 56'h0006, 0);
    check("R1", !gV, gV, 0);
    fieldOn = 1'b1;
    repeat (3) @(negedge clk);
    sendFrame(2, 56'h350E, 0);
    check("R1", !gV && !gS, {gV, gS}, 0);
    sendFrame(2, 56'h0006, 0);
    check("R1", gV && gK == 2'd1 && gId == 8'h35, {gV, gK, gId}, {1'b1, 2'd1, 8'h35});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule